// File: doc/BRIEF.md
# Boot-Time ROM Shadowing Controller

This block is the address-decode glue between a small 8-bit processor bus, a slow boot ROM and a fast RAM that occupies the same address window. After reset the system runs in a slow boot mode. Reads inside the window come from the ROM, and each one is stretched by pulling the ready line low. Writes to the window land in the RAM. Boot code therefore copies the firmware by reading each byte and writing it back to the same address.

When the copy is finished, the boot code touches one dedicated trigger address with a dummy access. That access sets the shadow flag, which stays set until the next reset. From then on, reads in the window come from the RAM. Wait states are no longer inserted and the fast clock is selected. As a build option, further writes into the window can be blocked. Every address outside the window is ordinary RAM in both modes.

All memory enables are active low and are asserted only while the bus clock phase input `bus_phase` is high. A write enable therefore cannot span an address change.

Top module: `romshadow_ctl`

## Requirements
- R1: While `rst_n` is low, the shadow flag is cleared: `fast_sel` is 0, `bus_rdy` is 1 for an access outside the window, and every enable is high (inactive) while `bus_phase` is low.
- R2: With the flag clear, a read (`bus_rd`=1) inside the window (default 0xE000 to 0xFFFF) drives `rom_oe_n` low during `bus_phase` high. `ram_oe_n` and `ram_we_n` stay high.
- R3: With the flag clear, a write (`bus_rd`=0) inside the window drives only `ram_we_n` low during `bus_phase` high. `rom_oe_n` and `ram_oe_n` stay high.
- R4: A read or write at the trigger address (default 0xDFFF) sets the flag from the next clock edge, and the flag holds until reset. The trigger address enables no memory.
- R5: With the flag set, a read inside the window drives `ram_oe_n` low and keeps `rom_oe_n` high.
- R6: With the flag set, `bus_rdy` stays 1 on every access and `fast_sel` is 1.
- R7: With the flag clear, a window read at a new address holds `bus_rdy` at 0 for exactly `WAIT_CYC` clock cycles (default 3), starting in the first cycle of the access, and then raises it.
  - An access counts as new when the previous cycle was not a slow window read or used a different address.
  - A new access reloads the count, even if the previous count had not run out.
- R8: With the flag set and `WRITE_PROTECT`=1, a write inside the window leaves `ram_we_n` high. With `WRITE_PROTECT`=0, such a write drives `ram_we_n` low.
- R9: Outside the window and away from the trigger, in either mode:
  - a read drives only `ram_oe_n` low;
  - a write drives only `ram_we_n` low;
  - `bus_rdy` is 1.
- R10: While `bus_phase` is low, `rom_oe_n`, `ram_oe_n` and `ram_we_n` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that advances bus cycles; state changes on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the shadow flag and the wait counter |
| bus_phase | input | 1 | Bus clock data phase; enables are asserted only while it is high |
| bus_addr | input | 16 | CPU address bus |
| bus_rd | input | 1 | 1 = read cycle, 0 = write cycle |
| rom_oe_n | output | 1 | ROM output enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| bus_rdy | output | 1 | Ready to the CPU; 0 inserts a wait state |
| fast_sel | output | 1 | Clock speed select; 1 = fast clock |

## Verification
The assertions take for granted that the processor keeps the address and direction steady for one whole clock cycle. They also assume that the trigger address lies outside the ROM window, so the trigger never overlaps a slow read. The stimulus changes inputs only on falling clock edges and uses the default map, with the trigger just below the window base. Wait-state stimulus holds an address for the full stall, as a stalled processor would, and once moves to a new address mid-stall to exercise the reload. Both `WRITE_PROTECT` settings are driven with the same stimulus, and a second reset checks that the flag clears and can be set again by a write.

// File: rtl/romshadow_pkg.sv
package romshadow_pkg;

    // Active-high memory selects, inverted and phase-gated at the top.
    typedef struct packed {
        logic rom_oe;
        logic ram_oe;
        logic ram_we;
    } mem_sel_t;

    localparam mem_sel_t SEL_NONE = '{rom_oe: 1'b0, ram_oe: 1'b0, ram_we: 1'b0};

endpackage

// File: rtl/romshadow_decode.sv
module romshadow_decode
    import romshadow_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned WIN_BASE      = 32'hE000,
    parameter int unsigned WIN_SIZE      = 8192,
    parameter int unsigned TRIG_ADDR     = 32'hDFFF,
    parameter bit          WRITE_PROTECT = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              shadow,
    output mem_sel_t          sel,
    output logic              in_win,
    output logic              trig_hit,
    output logic              slow_rd
);

    localparam int unsigned WIN_LAST = WIN_BASE + WIN_SIZE - 1;

    logic [31:0] addr_wide;

    always_comb begin
        addr_wide = 32'(addr);
        in_win    = (addr_wide >= WIN_BASE) && (addr_wide <= WIN_LAST);
        trig_hit  = (addr == ADDR_W'(TRIG_ADDR));
        slow_rd   = in_win && rd && !shadow && !trig_hit;
        sel       = SEL_NONE;
        if (trig_hit) begin
            sel = SEL_NONE;
        end else if (in_win) begin
            if (rd) begin
                if (shadow) sel.ram_oe = 1'b1;
                else        sel.rom_oe = 1'b1;
            end else if (!(shadow && WRITE_PROTECT)) begin
                sel.ram_we = 1'b1;
            end
        end else begin
            if (rd) sel.ram_oe = 1'b1;
            else    sel.ram_we = 1'b1;
        end
    end

endmodule

// File: rtl/romshadow_waiter.sv
module romshadow_waiter #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned WAIT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_rd,
    input  logic [ADDR_W-1:0] addr,
    output logic              rdy
);

    localparam int unsigned CNT_W  = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
    localparam int unsigned RELOAD = WAIT_CYC - 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] last_addr;
        logic              last_vld;
    } wait_st_t;

    wait_st_t st_d, st_q;
    logic     new_acc;

    always_comb begin
        new_acc = !(st_q.last_vld && (st_q.last_addr == addr));
        rdy     = !(slow_rd && (new_acc || (st_q.cnt != '0)));
        st_d    = st_q;
        if (slow_rd && new_acc) begin
            st_d.cnt = CNT_W'(RELOAD);
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.last_vld  = slow_rd;
        st_d.last_addr = addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.cnt) <= RELOAD);

    // R7
    new_read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_rd && new_acc) |-> !rdy);

endmodule

// File: rtl/romshadow_mode.sv
module romshadow_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_hit,
    output logic shadow
);

    typedef struct packed {
        logic flag;
    } mode_st_t;

    mode_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trig_hit) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shadow = st_q.flag;

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shadow |=> shadow);

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |=> shadow);

endmodule

// File: rtl/romshadow_ctl.sv
module romshadow_ctl
    import romshadow_pkg::*;
#(
    parameter int unsigned ADDR_W        = 16,
    parameter int unsigned WIN_BASE      = 32'hE000,
    parameter int unsigned WIN_SIZE      = 8192,
    parameter int unsigned TRIG_ADDR     = 32'hDFFF,
    parameter int unsigned WAIT_CYC      = 3,
    parameter bit          WRITE_PROTECT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_phase,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    output logic              rom_oe_n,
    output logic              ram_oe_n,
    output logic              ram_we_n,
    output logic              bus_rdy,
    output logic              fast_sel
);

    mem_sel_t sel;
    logic     in_win;
    logic     trig_hit;
    logic     slow_rd;
    logic     shadow;

    romshadow_decode #(
        .ADDR_W        (ADDR_W),
        .WIN_BASE      (WIN_BASE),
        .WIN_SIZE      (WIN_SIZE),
        .TRIG_ADDR     (TRIG_ADDR),
        .WRITE_PROTECT (WRITE_PROTECT)
    ) u_decode (
        .addr     (bus_addr),
        .rd       (bus_rd),
        .shadow   (shadow),
        .sel      (sel),
        .in_win   (in_win),
        .trig_hit (trig_hit),
        .slow_rd  (slow_rd)
    );

    romshadow_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_hit (trig_hit),
        .shadow   (shadow)
    );

    romshadow_waiter #(
        .ADDR_W   (ADDR_W),
        .WAIT_CYC (WAIT_CYC)
    ) u_waiter (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_rd (slow_rd),
        .addr    (bus_addr),
        .rdy     (bus_rdy)
    );

    always_comb begin
        rom_oe_n = !(sel.rom_oe && bus_phase);
        ram_oe_n = !(sel.ram_oe && bus_phase);
        ram_we_n = !(sel.ram_we && bus_phase);
        fast_sel = shadow;
    end

    // R10
    idle_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_phase |-> (rom_oe_n && ram_oe_n && ram_we_n));

    // R2
    oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rom_oe_n && !ram_oe_n));

    // R6
    fast_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_sel |-> bus_rdy);

    // R5
    no_rom_after_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fast_sel |-> rom_oe_n);

    generate
        if (WRITE_PROTECT) begin : g_wp
            // R8
            wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (fast_sel && in_win && !bus_rd) |-> ram_we_n);
        end
    endgenerate

endmodule

// File: tb/romshadow_ctl_test.sv
`timescale 1ns/1ps
module romshadow_ctl_test;

    localparam int W = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_phase = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic        bus_rd = 1'b1;
    logic rom_oe_n, ram_oe_n, ram_we_n, bus_rdy, fast_sel;
    logic rom_oe_n2, ram_oe_n2, ram_we_n2, bus_rdy2, fast_sel2;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_flag = 0;
    int m_stall = 0;
    int m_prev = -1;

    always #4 clk = ~clk;

    romshadow_ctl #(.WAIT_CYC(W), .WRITE_PROTECT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .rom_oe_n(rom_oe_n), .ram_oe_n(ram_oe_n),
        .ram_we_n(ram_we_n), .bus_rdy(bus_rdy), .fast_sel(fast_sel));

    romshadow_ctl #(.WAIT_CYC(W), .WRITE_PROTECT(1'b0)) uut_open (
        .clk(clk), .rst_n(rst_n), .bus_phase(bus_phase), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .rom_oe_n(rom_oe_n2), .ram_oe_n(ram_oe_n2),
        .ram_we_n(ram_we_n2), .bus_rdy(bus_rdy2), .fast_sel(fast_sel2));

    task automatic cmp(input string req, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic r, input logic p);
        bit trig, inwin, slow, isnew;
        logic e_rom, e_oe, e_we, e_we_open, e_rdy;
        string tag, rtag;
        @(negedge clk);
        bus_addr = a; bus_rd = r; bus_phase = p;
        #1;
        trig  = (a == 16'hDFFF);
        inwin = (a >= 16'hE000);
        slow  = inwin && r && (m_flag == 0);
        isnew = (m_prev != int'(a));
        e_rom = p && !trig && inwin && r && (m_flag == 0);
        e_oe  = p && !trig && r && (!inwin || m_flag != 0);
        e_we  = p && !trig && !r && (!inwin || m_flag == 0);
        e_we_open = p && !trig && !r;
        e_rdy = slow ? !(isnew || m_stall > 0) : 1'b1;
        if (trig) tag = "R4";
        else if (!p) tag = "R10";
        else if (!inwin) tag = "R9";
        else if (m_flag != 0) tag = r ? "R5" : "R8";
        else tag = r ? "R2" : "R3";
        rtag = slow ? "R7" : (m_flag != 0 ? "R6" : "R9");
        if (!rst_n) begin tag = "R1"; rtag = "R1"; end
        cmp(tag, "rom_oe_n", rom_oe_n, !e_rom);
        cmp(tag, "ram_oe_n", ram_oe_n, !e_oe);
        cmp(tag, "ram_we_n", ram_we_n, !e_we);
        cmp((inwin && m_flag != 0 && !r) ? "R8" : tag, "ram_we_n(open)", ram_we_n2, !e_we_open);
        cmp(rtag, "bus_rdy", bus_rdy, e_rdy);
        cmp(rst_n ? "R4 R6" : "R1", "fast_sel", fast_sel, m_flag != 0);
        @(posedge clk);
        if (rst_n) begin
            if (trig) m_flag = 1;
            if (slow && isnew) m_stall = W - 1;
            else if (m_stall > 0) m_stall--;
            m_prev = slow ? int'(a) : -1;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        m_flag = 0; m_stall = 0; m_prev = -1;
        step(16'h0000, 1'b1, 1'b0);   // R1
        step(16'h1234, 1'b1, 1'b0);   // R1
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R9 plain RAM before shadowing
        step(16'h0200, 1'b1, 1'b1);
        step(16'h0200, 1'b0, 1'b1);
        step(16'hDFFE, 1'b0, 1'b1);
        // R2 R3 R7 copy loop: read with stall, write back
        for (int i = 0; i < 4; i++) begin
            for (int k = 0; k <= W; k++) step(16'hE000 + 16'(i), 1'b1, 1'b1);
            step(16'hE000 + 16'(i), 1'b0, 1'b1);
        end
        step(16'hFFFF, 1'b1, 1'b1);
        step(16'hFFFF, 1'b1, 1'b1);
        step(16'hFFFF, 1'b1, 1'b1);
        step(16'hFFFF, 1'b1, 1'b1);
        // R7 reload: move to new address mid-stall
        step(16'hE100, 1'b1, 1'b1);
        step(16'hE100, 1'b1, 1'b1);
        step(16'hE101, 1'b1, 1'b1);
        for (int k = 0; k < W; k++) step(16'hE101, 1'b1, 1'b1);
        // R10 phase low everywhere
        step(16'hE200, 1'b1, 1'b0);
        step(16'hE200, 1'b0, 1'b0);
        step(16'h0300, 1'b0, 1'b0);
        // R4 dummy read of trigger
        step(16'hDFFF, 1'b1, 1'b1);
        // R5 R6 R8 R9 shadow mode
        step(16'hE000, 1'b1, 1'b1);
        step(16'hE001, 1'b1, 1'b1);
        step(16'hFFFF, 1'b0, 1'b1);
        step(16'hE000, 1'b0, 1'b1);
        step(16'h0400, 1'b1, 1'b1);
        step(16'h0400, 1'b0, 1'b1);
        step(16'hDFFF, 1'b0, 1'b1);
        step(16'hE003, 1'b1, 1'b0);
        step(16'hE003, 1'b1, 1'b1);
        // R1 second reset, then R4 set by a write
        do_reset();
        step(16'hE010, 1'b1, 1'b1);
        step(16'hDFFF, 1'b0, 1'b1);
        step(16'hE010, 1'b1, 1'b1);
        step(16'hE010, 1'b0, 1'b1);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule